// File: doc/BRIEF.md
# Register-Staged Word Memory

This block is a small word-addressed RAM that is never reached directly. A requester first places an address in the address staging register and, for a write, a value in the data staging register. It then raises `start` for one cycle, with `op_store` choosing between a fetch and a store. The block decodes the staged address into a one-hot cell select. It then either copies the selected cell into the data staging register or writes that register into the cell.

Every operation takes the same two cycles, whatever the address. A one-cycle `done` pulse marks completion. The data staging register is the only read path, and it keeps its value until the next fetch or an explicit load.

The controller has three named states. `ST_IDLE` accepts loads and `start`. `ST_DECODE` registers the one-hot select. `ST_XFER` performs the transfer. Its transitions are: `ST_IDLE` to `ST_DECODE` on `start`; `ST_DECODE` to `ST_XFER` unconditionally; `ST_XFER` back to `ST_IDLE` unconditionally, with `done` raised in the following cycle.

Top module: `staged_mem`

## Requirements
- R1: After reset `busy` is 0, `done` is 0, and `data_out` (the data staging register) is 0.
- R2: A fetch (`op_store` = 0 at `start`) copies the cell at the staged address into the data staging register. The value is visible on `data_out` in the same cycle as `done`.
- R3: A store (`op_store` = 1 at `start`) writes the data staging register into the cell at the staged address. It overwrites the previous content, which a later fetch shows.
- R4: A fetch is non-destructive: fetching the same cell again returns the same value.
- R5: `done` is a one-cycle pulse. It is raised exactly two clock cycles after the edge that accepted `start`, for every address. `busy` is high during exactly those two cycles.
- R6: `start` raised while `busy` is high is ignored: it produces no extra operation and no extra `done`.
- R7: `addr_ld` and `data_ld` are ignored while `busy` is high. The staged address and data are unchanged by such loads.
- R8: The data staging register keeps its value across a store and while idle without `data_ld`. After a store, `data_out` still shows the stored value.
- R9: With an `ADDR_W`-bit address there are 2^`ADDR_W` distinct cells. Address 0 and address 2^`ADDR_W` − 1 are both reachable and independent.
- R10: An address or data load given in the same idle cycle as `start` is used by that operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_ld | input | 1 | Load `addr_in` into the address staging register (idle only) |
| addr_in | input | ADDR_W | Address to stage |
| data_ld | input | 1 | Load `data_in` into the data staging register (idle only) |
| data_in | input | DATA_W | Value to stage |
| op_store | input | 1 | Operation select at `start`: 1 = store, 0 = fetch |
| start | input | 1 | Begin an operation (accepted only when idle) |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| data_out | output | DATA_W | Content of the data staging register |

## Verification
The bench builds the block with `ADDR_W` = 4 and `DATA_W` = 8, giving sixteen cells. With that size the lowest and highest cells can be exercised and told apart, and overwriting and repeated fetches can be followed cell by cell. A directed sequence fires `start` and both loads in the middle of a fetch. It then fetches again without reloading, which exposes any leaked address or data load. A store-only sequence shows that the staging register is left holding the written value.

// File: rtl/staged_mem_pkg.sv
package staged_mem_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_XFER   = 2'd2
    } stage_state_t;
endpackage

// File: rtl/stage_ctrl.sv
module stage_ctrl
    import staged_mem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic op_store,
    output logic busy,
    output logic dec_en,
    output logic wr_en,
    output logic rd_en,
    output logic done
);
    stage_state_t state_q, state_d;
    logic         op_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_DECODE;
            ST_DECODE: state_d = ST_XFER;
            ST_XFER:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= 1'b0;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= (state_q == ST_XFER);
            if (state_q == ST_IDLE && start) op_q <= op_store;
        end
    end

    always_comb begin
        busy   = 1'b0;
        dec_en = 1'b0;
        wr_en  = 1'b0;
        rd_en  = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_DECODE: begin busy = 1'b1; dec_en = 1'b1; end
            ST_XFER:   begin busy = 1'b1; wr_en = op_q; rd_en = !op_q; end
            default:   ;
        endcase
    end
endmodule

// File: rtl/stage_regs.sv
module stage_regs #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              addr_ld,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              data_ld,
    input  logic [DATA_W-1:0] data_in,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mar,
    output logic [DATA_W-1:0] mdr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar <= '0;
            mdr <= '0;
        end else begin
            if (addr_ld && !busy) mar <= addr_in;
            if (rd_en)                 mdr <= rd_data;
            else if (data_ld && !busy) mdr <= data_in;
        end
    end
endmodule

// File: rtl/stage_ram.sv
module stage_ram #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0]  hot;
    logic [DEPTH-1:0]  sel_q;
    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_dec
        assign hot[i] = (addr == ADDR_W'(i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (dec_en) sel_q <= hot;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_en && sel_q[i]) cells[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sel_q[i]) rdata = rdata | cells[i];
        end
    end
endmodule

// File: rtl/staged_mem.sv
module staged_mem #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_ld,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              data_ld,
    input  logic [DATA_W-1:0] data_in,
    input  logic              op_store,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] data_out
);
    logic              dec_en, wr_en, rd_en;
    logic [ADDR_W-1:0] mar;
    logic [DATA_W-1:0] rd_data;

    stage_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .op_store(op_store),
        .busy(busy), .dec_en(dec_en), .wr_en(wr_en), .rd_en(rd_en), .done(done)
    );

    stage_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .addr_ld(addr_ld), .addr_in(addr_in),
        .data_ld(data_ld), .data_in(data_in),
        .rd_en(rd_en), .rd_data(rd_data),
        .mar(mar), .mdr(data_out)
    );

    stage_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .wr_en(wr_en),
        .addr(mar), .wdata(data_out), .rdata(rd_data)
    );
endmodule

// File: rtl/staged_mem_chk.sv
module staged_mem_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              data_ld,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] data_out
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R5
    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);  // R5
    AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);  // R5
    AST_NO_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |=> !done);  // R6
    AST_MDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_ld && !busy) |=> (done || $stable(data_out)));  // R7
endmodule

bind staged_mem staged_mem_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .data_ld(data_ld),
    .busy(busy), .done(done), .data_out(data_out)
);

// File: tb/staged_mem_tb_top.sv
`timescale 1ns/100ps
module staged_mem_tb_top;
    localparam int AW = 4;
    localparam int DW = 8;

    typedef struct packed {
        logic          st;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd3,  8'hA5},
        '{1'b1, 4'd0,  8'h11},
        '{1'b1, 4'd15, 8'hEE},
        '{1'b1, 4'd7,  8'h3C},
        '{1'b0, 4'd3,  8'hA5},
        '{1'b0, 4'd15, 8'hEE},
        '{1'b0, 4'd0,  8'h11},
        '{1'b1, 4'd3,  8'h5A},
        '{1'b0, 4'd3,  8'h5A},
        '{1'b0, 4'd7,  8'h3C},
        '{1'b0, 4'd7,  8'h3C}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_ld = 1'b0, data_ld = 1'b0, op_store = 1'b0, start = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] data_in = '0;
    logic          busy, done;
    logic [DW-1:0] data_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    staged_mem #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_in(addr_in),
        .data_ld(data_ld), .data_in(data_in), .op_store(op_store), .start(start),
        .busy(busy), .done(done), .data_out(data_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Issue at a negedge; returns at the negedge where done must be seen.
    task automatic run_op(input logic st, input logic lda, input logic [AW-1:0] a,
                          input logic ldd, input logic [DW-1:0] d);
        logic ok;
        ok = 1'b1;
        addr_ld = lda; addr_in = a; data_ld = ldd; data_in = d;
        op_store = st; start = 1'b1;
        @(negedge clk);
        addr_ld = 1'b0; data_ld = 1'b0; start = 1'b0;
        if (!(busy === 1'b1 && done === 1'b0)) ok = 1'b0;
        @(negedge clk);
        if (!(busy === 1'b1 && done === 1'b0)) ok = 1'b0;
        @(negedge clk);
        if (!(busy === 1'b0 && done === 1'b1)) ok = 1'b0;
        check("R5 two-cycle latency", {31'd0, ok}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy after reset", {31'd0, busy}, 32'd0);
        check("R1 done after reset", {31'd0, done}, 32'd0);
        check("R1 data_out after reset", {24'd0, data_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: stores (R3, R9, R10) and fetches (R2, R4)
        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].st, 1'b1, VECS[i].a, VECS[i].st, VECS[i].d);
            if (!VECS[i].st)
                check("R2/R3/R4 fetched value", {24'd0, data_out}, {24'd0, VECS[i].d});
            @(negedge clk);
        end

        // R8: store leaves the stored value in the staging register
        run_op(1'b1, 1'b1, 4'd9, 1'b1, 8'h77);
        check("R8 data_out after store", {24'd0, data_out}, 32'h77);
        repeat (3) @(negedge clk);
        check("R8 data_out held while idle", {24'd0, data_out}, 32'h77);

        // R6 / R7: start and loads during a fetch of cell 15
        addr_ld = 1'b1; addr_in = 4'd15; op_store = 1'b0; start = 1'b1;
        @(negedge clk);
        check("R5 busy in decode", {31'd0, busy}, 32'd1);
        addr_ld = 1'b1; addr_in = 4'd3; data_ld = 1'b1; data_in = 8'h00;
        op_store = 1'b1; start = 1'b1;
        @(negedge clk);
        addr_ld = 1'b0; data_ld = 1'b0; start = 1'b0; op_store = 1'b0;
        check("R6 no early done", {31'd0, done}, 32'd0);
        @(negedge clk);
        check("R6 done on time", {31'd0, done}, 32'd1);
        check("R7 fetch ignores busy data load", {24'd0, data_out}, 32'hEE);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R6 no extra done", {31'd0, done}, 32'd0);
        end
        check("R7 data_out held", {24'd0, data_out}, 32'hEE);
        run_op(1'b0, 1'b0, 4'd0, 1'b0, 8'h00);
        check("R7 staged address kept", {24'd0, data_out}, 32'hEE);
        @(negedge clk);
        run_op(1'b0, 1'b1, 4'd3, 1'b0, 8'h00);
        check("R6 ignored store wrote nothing", {24'd0, data_out}, 32'h5A);
        @(negedge clk);

        // R9: extreme cells independent after rewriting one
        run_op(1'b1, 1'b1, 4'd15, 1'b1, 8'h81);
        @(negedge clk);
        run_op(1'b0, 1'b1, 4'd0, 1'b0, 8'h00);
        check("R9 cell 0 untouched", {24'd0, data_out}, 32'h11);
        @(negedge clk);
        run_op(1'b0, 1'b1, 4'd15, 1'b0, 8'h00);
        check("R9 top cell rewritten", {24'd0, data_out}, 32'h81);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule